// File: doc/BRIEF.md
# Write Transaction ID Allocator

This block hands out 5-bit write transaction IDs to write requests coming from up to four cores and from one cluster-level barrier source. Every request arrives with a descriptor: the requesting core, a request kind and a flag that says whether the target is inner and outer write-back cacheable Normal memory. The block answers with a grant that carries the chosen ID, or it stalls the request. The ID itself encodes the source and the class of the write, so downstream logic can route responses by their ID alone.

The request side is a valid/ready handshake. `req_ready` is computed from the registered occupancy state and from the descriptor fields; it does not depend on `req_valid`. A request is granted in the cycle where `req_valid` and `req_ready` are both high, and `gnt_id` is valid in that same cycle. A requester whose request is stalled must hold its descriptor stable until it is granted. Responses arrive on a plain valid strobe with the returned ID. They are always accepted and take effect at the next clock edge. A release does not raise `req_ready` until the following cycle.

A returned ID that is not outstanding sets a sticky error output. Such a response changes no other state. The error output clears only on reset.

Top module: `wid_alloc`

## Requirements
- R1: After reset, no ID is outstanding and `err_rsp` is 0. `req_ready` is 1 for every legal kind (kind codes 0 to 4) from any core.
- R2: A kind-0 request (Normal memory or reorderable device write) is granted an ID of the form 1xxxx, that is 16 plus an index. The lowest-numbered free index is chosen.
- R3: Each 1xxxx ID holds at most one outstanding write. A response with that ID frees it, and the freed ID can be granted again.
- R4: A kind-1 request (non-reorderable device write) from core c is granted ID {011,c}. Up to 15 of them may be outstanding per core. With 15 outstanding, a further request from that core stalls.
- R5: When a kind-1 grant and a response on the same 011c ID happen in the same cycle, the outstanding count for that core is unchanged.
- R6: A kind-2 request (exclusive store) from core c is granted ID {000,c}. At most one may be outstanding per core.
- R7: A kind-3 request (core barrier) from core c is granted ID {001,c}. At most one may be outstanding per core. Barriers are not counted against the non-barrier limits.
- R8: A kind-4 request (cluster barrier) is granted ID 01001. At most one may be outstanding.
- R9: At most 16 writes of kinds 0, 1 and 2 may be outstanding in total. A further request of those kinds stalls.
- R10: At most 15 outstanding writes may be not write-back cacheable. These are kind 0 or kind 2 requests with `req_wb`=0, and every kind-1 request. A further such request stalls, while a write-back kind-0 request is still granted.
- R11: A stalled request changes no state.
- R12: A response whose ID is not outstanding sets `err_rsp` one cycle later. The flag stays set, and the response changes no other state.
- R13: IDs 01000 and 0101x are never granted. Kind codes 5 to 7 are never ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Request can be granted this cycle |
| req_core | input | 2 | Requesting core number |
| req_kind | input | 3 | 0 normal, 1 non-reorderable device, 2 exclusive, 3 core barrier, 4 cluster barrier |
| req_wb | input | 1 | Target is write-back cacheable Normal memory |
| gnt_id | output | 5 | ID granted when valid and ready are both high |
| rsp_valid | input | 1 | Write response returned |
| rsp_id | input | 5 | ID of the returned response |
| err_rsp | output | 1 | Sticky: a response named an ID that was not outstanding |

## Verification
Sixteen back-to-back write-back normal requests show that the lowest free ID is picked and that the pool and the total limit both stall. A freed middle ID then shows that it is reused ahead of higher ones. A run of non-write-back normal requests tells the 15-entry cacheability cap apart from the 16-entry total, because a write-back request still gets through. Stacking device writes on one core, with a grant and a response coinciding at count 14, separates correct counter behaviour from double counting. Single-outstanding classes, barriers and stray responses are each driven on their own.

// File: rtl/wid_pkg.sv
package wid_pkg;
  localparam int ID_W   = 5;
  localparam int CORE_W = 2;
  localparam int NCORES = 1 << CORE_W;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_NORM  = 3'd0,
    K_DEVNR = 3'd1,
    K_EXCL  = 3'd2,
    K_BAR   = 3'd3,
    K_CLBAR = 3'd4
  } kind_e;

  // Fixed ID prefixes (three upper bits) for core-numbered classes
  localparam logic [2:0] PFX_EXCL  = 3'b000;
  localparam logic [2:0] PFX_BAR   = 3'b001;
  localparam logic [2:0] PFX_DEVNR = 3'b011;
  localparam logic [ID_W-1:0] ID_CLBAR = 5'b01001;
endpackage

// File: rtl/wid_pool.sv
module wid_pool #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_wb,
  input  logic             rel,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             any_free,
  output logic [IDX_W-1:0] free_idx,
  output logic             busy_at_rel,
  output logic             wb_at_rel
);
  logic [N-1:0] busy_q;
  logic [N-1:0] wb_q;

  // Lowest free entry wins: scan from the top so the last match is lowest
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign busy_at_rel = busy_q[rel_idx];
  assign wb_at_rel   = wb_q[rel_idx];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic set_e, clr_e;
    assign set_e = take && (free_idx == IDX_W'(g));
    assign clr_e = rel && (rel_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        wb_q[g]   <= 1'b0;
      end else if (set_e) begin
        busy_q[g] <= 1'b1;
        wb_q[g]   <= take_wb;
      end else if (clr_e) begin
        busy_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wid_dev_ctr.sv
module wid_dev_ctr #(
  parameter int MAX = 15,
  localparam int CNT_W = $clog2(MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic empty
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full  = (cnt_q == LIM);
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/wid_flag.sv
module wid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic set_wb,
  input  logic clr,
  output logic busy,
  output logic wb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wb   <= 1'b0;
    end else if (set) begin
      busy <= 1'b1;
      wb   <= set_wb;
    end else if (clr) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/wid_alloc.sv
module wid_alloc
  import wid_pkg::*;
#(
  parameter int POOL_N    = 16,
  parameter int DEV_MAX   = 15,
  parameter int TOTAL_MAX = 16,
  parameter int NONWB_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_wb,
  output logic [ID_W-1:0]   gnt_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  output logic              err_rsp
);
  localparam int IDX_W = $clog2(POOL_N);
  localparam int TOT_W = $clog2(TOTAL_MAX + 1);
  localparam int NWB_W = $clog2(NONWB_MAX + 1);
  localparam logic [TOT_W-1:0] TOT_LIM = TOT_W'(TOTAL_MAX);
  localparam logic [NWB_W-1:0] NWB_LIM = NWB_W'(NONWB_MAX);

  logic fire;
  assign fire = req_valid && req_ready;

  // ---------------- response decode ----------------
  logic [CORE_W-1:0] rsp_core;
  logic              rsp_pool, rsp_dev, rsp_excl, rsp_bar, rsp_clbar;
  assign rsp_core  = rsp_id[CORE_W-1:0];
  assign rsp_pool  = rsp_id[ID_W-1];
  assign rsp_dev   = (rsp_id[ID_W-1:CORE_W] == PFX_DEVNR);
  assign rsp_excl  = (rsp_id[ID_W-1:CORE_W] == PFX_EXCL);
  assign rsp_bar   = (rsp_id[ID_W-1:CORE_W] == PFX_BAR);
  assign rsp_clbar = (rsp_id == ID_CLBAR);

  // ---------------- pool of reorderable IDs ----------------
  logic             pool_free, pool_busy_rel, pool_wb_rel, pool_take, pool_rel;
  logic [IDX_W-1:0] pool_idx;

  wid_pool #(.N(POOL_N)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (pool_take),
    .take_wb    (req_wb),
    .rel        (pool_rel),
    .rel_idx    (rsp_id[IDX_W-1:0]),
    .any_free   (pool_free),
    .free_idx   (pool_idx),
    .busy_at_rel(pool_busy_rel),
    .wb_at_rel  (pool_wb_rel)
  );

  // ---------------- per-core classes ----------------
  logic [NCORES-1:0] dev_full, dev_empty, dev_inc, dev_dec;
  logic [NCORES-1:0] ex_busy, ex_wb, ex_set, ex_clr;
  logic [NCORES-1:0] br_busy, br_set, br_clr;
  logic [NCORES-1:0] br_wb_unused;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic core_hit, rsp_hit;
    assign core_hit = fire && (req_core == CORE_W'(c));
    assign rsp_hit  = rsp_valid && (rsp_core == CORE_W'(c));

    assign dev_inc[c] = core_hit && (req_kind == K_DEVNR);
    assign dev_dec[c] = rsp_hit && rsp_dev && !dev_empty[c];
    assign ex_set[c]  = core_hit && (req_kind == K_EXCL);
    assign ex_clr[c]  = rsp_hit && rsp_excl && ex_busy[c];
    assign br_set[c]  = core_hit && (req_kind == K_BAR);
    assign br_clr[c]  = rsp_hit && rsp_bar && br_busy[c];

    wid_dev_ctr #(.MAX(DEV_MAX)) u_dev (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (dev_inc[c]),
      .dec  (dev_dec[c]),
      .full (dev_full[c]),
      .empty(dev_empty[c])
    );

    wid_flag u_ex (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ex_set[c]),
      .set_wb(req_wb),
      .clr   (ex_clr[c]),
      .busy  (ex_busy[c]),
      .wb    (ex_wb[c])
    );

    wid_flag u_br (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (br_set[c]),
      .set_wb(1'b0),
      .clr   (br_clr[c]),
      .busy  (br_busy[c]),
      .wb    (br_wb_unused[c])
    );
  end

  // ---------------- cluster barrier ----------------
  logic cb_busy, cb_set, cb_clr, cb_wb_unused;
  assign cb_set = fire && (req_kind == K_CLBAR);
  assign cb_clr = rsp_valid && rsp_clbar && cb_busy;

  wid_flag u_cb (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cb_set),
    .set_wb(1'b0),
    .clr   (cb_clr),
    .busy  (cb_busy),
    .wb    (cb_wb_unused)
  );

  // ---------------- response classification ----------------
  logic rsp_known, rel_nonwb;
  always_comb begin
    rsp_known = 1'b0;
    rel_nonwb = 1'b0;
    if (rsp_pool) begin
      rsp_known = pool_busy_rel;
      rel_nonwb = !pool_wb_rel;
    end else if (rsp_dev) begin
      rsp_known = !dev_empty[rsp_core];
      rel_nonwb = 1'b1;
    end else if (rsp_excl) begin
      rsp_known = ex_busy[rsp_core];
      rel_nonwb = !ex_wb[rsp_core];
    end else if (rsp_bar) begin
      rsp_known = br_busy[rsp_core];
    end else if (rsp_clbar) begin
      rsp_known = cb_busy;
    end
  end

  assign pool_rel  = rsp_valid && rsp_pool && pool_busy_rel;
  assign pool_take = fire && (req_kind == K_NORM);

  // ---------------- global occupancy ----------------
  logic [TOT_W-1:0] tot_q;
  logic [NWB_W-1:0] nwb_q;
  logic tot_inc, tot_dec, nwb_inc, nwb_dec;
  logic counted_kind, req_nonwb;

  assign counted_kind = (req_kind == K_NORM) || (req_kind == K_DEVNR) ||
                        (req_kind == K_EXCL);
  assign req_nonwb    = (req_kind == K_DEVNR) || !req_wb;

  assign tot_inc = fire && counted_kind;
  assign nwb_inc = fire && counted_kind && req_nonwb;
  assign tot_dec = rsp_valid && rsp_known && (rsp_pool || rsp_dev || rsp_excl);
  assign nwb_dec = tot_dec && rel_nonwb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot_q <= '0;
      nwb_q <= '0;
    end else begin
      case ({tot_inc, tot_dec})
        2'b10:   tot_q <= tot_q + 1'b1;
        2'b01:   tot_q <= tot_q - 1'b1;
        default: tot_q <= tot_q;
      endcase
      case ({nwb_inc, nwb_dec})
        2'b10:   nwb_q <= nwb_q + 1'b1;
        2'b01:   nwb_q <= nwb_q - 1'b1;
        default: nwb_q <= nwb_q;
      endcase
    end
  end

  // ---------------- sticky error ----------------
  always_ff @(posedge clk) begin
    if (!rst_n)                      err_rsp <= 1'b0;
    else if (rsp_valid && !rsp_known) err_rsp <= 1'b1;
  end

  // ---------------- grant decision ----------------
  logic room_tot, room_nwb;
  assign room_tot = (tot_q != TOT_LIM);
  assign room_nwb = (nwb_q != NWB_LIM);

  always_comb begin
    req_ready = 1'b0;
    gnt_id    = '0;
    case (req_kind)
      K_NORM: begin
        req_ready = pool_free && room_tot && (req_wb || room_nwb);
        gnt_id    = {1'b1, pool_idx};
      end
      K_DEVNR: begin
        req_ready = !dev_full[req_core] && room_tot && room_nwb;
        gnt_id    = {PFX_DEVNR, req_core};
      end
      K_EXCL: begin
        req_ready = !ex_busy[req_core] && room_tot && (req_wb || room_nwb);
        gnt_id    = {PFX_EXCL, req_core};
      end
      K_BAR: begin
        req_ready = !br_busy[req_core];
        gnt_id    = {PFX_BAR, req_core};
      end
      K_CLBAR: begin
        req_ready = !cb_busy;
        gnt_id    = ID_CLBAR;
      end
      default: begin
        req_ready = 1'b0;
        gnt_id    = '0;
      end
    endcase
  end
endmodule

// File: rtl/wid_alloc_chk.sv
module wid_alloc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_core,
  input logic [2:0] req_kind,
  input logic [4:0] gnt_id,
  input logic       rsp_valid,
  input logic [4:0] rsp_id,
  input logic       err_rsp
);
  // R13
  reserved_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (gnt_id != 5'b01000 && gnt_id[4:1] != 4'b0101));

  // R13
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind > 3'd4) |-> !req_ready);

  // R2
  norm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 3'd0) |-> gnt_id[4]);

  // R4
  dev_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 3'd1) |-> (gnt_id == {3'b011, req_core}));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rsp |=> err_rsp);

  // R12
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_id == 5'b01000) |=> err_rsp);
endmodule

bind wid_alloc wid_alloc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_core (req_core),
  .req_kind (req_kind),
  .gnt_id   (gnt_id),
  .rsp_valid(rsp_valid),
  .rsp_id   (rsp_id),
  .err_rsp  (err_rsp)
);

// File: tb/wid_alloc_test.sv
`timescale 1ns/1ps
module wid_alloc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_core = '0;
  logic [2:0] req_kind = '0;
  logic       req_wb = 1'b0;
  logic [4:0] gnt_id;
  logic       rsp_valid = 1'b0;
  logic [4:0] rsp_id = '0;
  logic       err_rsp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wid_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_kind(req_kind), .req_wb(req_wb), .gnt_id(gnt_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .err_rsp(err_rsp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int core, input int kind, input int wb,
                       input int exp_rdy, input int exp_id, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_core = core[1:0]; req_kind = kind[2:0]; req_wb = wb[0];
    #1;
    chk({tag, " ready"}, int'(req_ready), exp_rdy);
    if (exp_rdy != 0) chk({tag, " id"}, int'(gnt_id), exp_id);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic respond(input int id);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_id = id[4:0];
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic peek_ready(input int core, input int kind, input int wb,
                            input int exp_rdy, input string tag);
    @(negedge clk);
    req_valid = 1'b0; req_core = core[1:0]; req_kind = kind[2:0]; req_wb = wb[0];
    #1;
    chk(tag, int'(req_ready), exp_rdy);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 5; k++) peek_ready(1, k, 0, 1, "R1 ready after reset");
    chk("R1 err after reset", int'(err_rsp), 0);
    for (int k = 5; k < 8; k++) peek_ready(0, k, 1, 0, "R13 illegal kind");
  endtask

  task automatic t_normal;
    for (int i = 0; i < 16; i++) issue(0, 0, 1, 1, 16 + i, "R2 lowest free");
    issue(0, 0, 1, 0, 0, "R9 pool/total full normal");
    issue(1, 2, 1, 0, 0, "R9 total full excl");
    issue(2, 1, 0, 0, 0, "R9 total full dev");
    issue(0, 3, 0, 1, 4, "R7 barrier not counted");
    respond(4);
    for (int i = 0; i < 3; i++) issue(0, 0, 1, 0, 0, "R11 held stall");
    respond(21);
    issue(0, 0, 1, 1, 21, "R3 freed id reused");
    issue(0, 0, 1, 0, 0, "R11 no hidden slot");
    for (int i = 16; i < 32; i++) respond(i);
    chk("R3 no error on release", int'(err_rsp), 0);
  endtask

  task automatic t_nonwb;
    for (int i = 0; i < 15; i++) issue(1, 0, 0, 1, 16 + i, "R10 nonwb fill");
    issue(1, 0, 0, 0, 0, "R10 nonwb normal stall");
    issue(3, 1, 0, 0, 0, "R10 dev stall");
    issue(1, 2, 0, 0, 0, "R10 nonwb excl stall");
    issue(1, 0, 1, 1, 31, "R10 wb still granted");
    for (int i = 16; i < 32; i++) respond(i);
    peek_ready(1, 0, 0, 1, "R10 nonwb ready after drain");
  endtask

  task automatic t_dev;
    for (int i = 0; i < 15; i++) issue(2, 1, 0, 1, 14, "R4 dev stack");
    issue(2, 1, 0, 0, 0, "R4 16th dev stall");
    issue(1, 1, 0, 0, 0, "R10 dev other core capped");
    respond(14);
    // grant and response coincide at count 14
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'd2; req_kind = 3'd1; req_wb = 1'b0;
    rsp_valid = 1'b1; rsp_id = 5'd14;
    #1;
    chk("R5 same-cycle ready", int'(req_ready), 1);
    chk("R5 same-cycle id", int'(gnt_id), 14);
    @(posedge clk); #1;
    req_valid = 1'b0; rsp_valid = 1'b0;
    issue(2, 1, 0, 1, 14, "R5 count unchanged slot");
    issue(2, 1, 0, 0, 0, "R5 count full again");
    for (int i = 0; i < 15; i++) respond(14);
    peek_ready(2, 1, 0, 1, "R4 dev ready after drain");
    chk("R4 no error", int'(err_rsp), 0);
  endtask

  task automatic t_excl;
    issue(1, 2, 1, 1, 1, "R6 excl core1");
    issue(1, 2, 1, 0, 0, "R6 second excl stall");
    issue(3, 2, 0, 1, 3, "R6 excl core3");
    respond(1);
    issue(1, 2, 1, 1, 1, "R6 excl after release");
    respond(1);
    respond(3);
  endtask

  task automatic t_barrier;
    issue(0, 3, 0, 1, 4, "R7 barrier core0");
    issue(0, 3, 0, 0, 0, "R7 second barrier stall");
    issue(3, 3, 0, 1, 7, "R7 barrier core3");
    issue(2, 4, 0, 1, 9, "R8 cluster barrier");
    issue(0, 4, 0, 0, 0, "R8 second cluster stall");
    respond(9);
    issue(1, 4, 0, 1, 9, "R8 cluster after release");
    respond(9); respond(4); respond(7);
    chk("R8 no error", int'(err_rsp), 0);
  endtask

  task automatic t_unknown;
    issue(0, 2, 1, 1, 0, "R12 setup excl");
    respond(20);
    chk("R12 err set", int'(err_rsp), 1);
    issue(0, 2, 1, 0, 0, "R12 state unchanged");
    respond(8);
    respond(0);
    issue(0, 2, 1, 1, 0, "R12 real release works");
    chk("R12 err sticky", int'(err_rsp), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_normal;
    t_nonwb;
    t_dev;
    t_excl;
    t_barrier;
    t_unknown;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule